// File: doc/BRIEF.md
# Capture Ring Writer

This block sits between a serial audio receiver and system memory. It takes 32-bit audio words on a valid/ready stream and stores each one as a 4-byte beat into a circular buffer in memory, through a valid/ready memory write port. A small register block sets the buffer's base address and its size in bytes, and an enable. It also holds two byte indices into the buffer. The hardware owns the producer index and moves it after every stored beat. Software owns the consumer index and moves it as it reads data out of the buffer.

The ring is never allowed to fill completely. If storing one more beat would bring the producer index up to the consumer index, the block stops taking samples until software moves the consumer index. Unread data is never overwritten and no sample is dropped. Back-pressure works in both directions. A sample is taken only in a cycle where the memory port accepts a beat. The memory port offers a beat only while a sample is waiting and the ring has room. A synchronous soft reset clears the stream state so that software can program the block again.

Top module: `ringcap_top`

## Requirements
- R1: After reset the enable, producer index and consumer index read as zero, and both `mem_valid` and `smp_ready` are low.
- R2: The register word selected by `reg_addr[4:2]` reads back on `reg_rdata` in the same cycle: 0 is the enable (bit 0), 1 is the base address, 2 is the size in bytes, 3 is the producer index and 4 is the consumer index. Other selections read zero. Writes through `reg_we` take effect at the next clock edge.
- R3: A register write to the producer index (selection 3) is ignored, and the index keeps its value.
- R4: While enabled with room in the ring, `mem_valid` follows `smp_valid`, `mem_addr` equals base plus producer index, `mem_data` equals `smp_data`, and `smp_ready` equals `mem_ready`.
- R5: Each accepted beat (`mem_valid` and `mem_ready` both high) advances the producer index by 4, wrapping with the mask (size − 1). The size must be a power of two.
- R6: When (producer + 4) & (size − 1) equals the consumer index, `mem_valid` and `smp_ready` stay low and the producer index holds.
- R7: Once software writes a consumer index that leaves room, beats resume from the held producer index.
- R8: While the enable is 0, no beat is offered and the producer index holds. Setting the enable again resumes at base plus the current producer index.
- R9: A pulse on `soft_rst` clears the producer index, the consumer index and the enable at the next edge. It leaves the base and the size unchanged.
- R10: While `mem_ready` is low, no sample is taken (`smp_ready` low) and the producer index holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous stream reset pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address; bits 4:2 select the word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| smp_valid | input | 1 | Sample available |
| smp_data | input | 32 | Sample word |
| smp_ready | output | 1 | Sample taken this cycle when `smp_valid` is also high |
| mem_valid | output | 1 | Memory write beat offered |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_data | output | 32 | Beat data |
| mem_ready | input | 1 | Memory accepts the beat |

## Verification
The bench builds the block with IDX_W = 8 and ADDR_W = 32. It programs buffers of 16 and 32 bytes, so wrap-around and the full-ring stall come up within a few beats. A 16-byte ring holds at most three words, which makes the stall points exact and easy to predict. A randomized phase with random source and sink stalls, and random consumer moves, then pushes hundreds of beats through the ring. In that phase the producer index wraps many times against an independent model.

// File: rtl/ringcap_pkg.sv
package ringcap_pkg;
  localparam int DATA_W     = 32;
  localparam int REG_AW     = 5;
  localparam int UNIT_BYTES = DATA_W / 8;

  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_BASE   = 3'd1,
    SEL_SIZE   = 3'd2,
    SEL_PROD   = 3'd3,
    SEL_CONS   = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/ringcap_regs.sv
module ringcap_regs
  import ringcap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  prod_idx,
  output logic [DATA_W-1:0] rdata,
  output logic              enable,
  output logic [ADDR_W-1:0] base,
  output logic [IDX_W-1:0]  size,
  output logic [IDX_W-1:0]  cons_idx
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr[4:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      base     <= '0;
      size     <= '0;
      cons_idx <= '0;
    end else begin
      if (soft_rst) begin
        enable   <= 1'b0;
        cons_idx <= '0;
      end else if (we) begin
        if (sel == SEL_ENABLE) enable   <= wdata[0];
        if (sel == SEL_CONS)   cons_idx <= wdata[IDX_W-1:0];
      end
      if (we && sel == SEL_BASE) base <= wdata[ADDR_W-1:0];
      if (we && sel == SEL_SIZE) size <= wdata[IDX_W-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ENABLE: rdata = DATA_W'(enable);
      SEL_BASE:   rdata = DATA_W'(base);
      SEL_SIZE:   rdata = DATA_W'(size);
      SEL_PROD:   rdata = DATA_W'(prod_idx);
      SEL_CONS:   rdata = DATA_W'(cons_idx);
      default:    rdata = '0;
    endcase
  end

  assert_soft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!enable && cons_idx == '0));
endmodule

// File: rtl/ringcap_space.sv
module ringcap_space
  import ringcap_pkg::*;
#(
  parameter int IDX_W = 22
) (
  input  logic [IDX_W-1:0] prod_idx,
  input  logic [IDX_W-1:0] cons_idx,
  input  logic [IDX_W-1:0] size,
  output logic [IDX_W-1:0] next_idx,
  output logic             room
);
  localparam logic [IDX_W-1:0] STEP = IDX_W'(UNIT_BYTES);
  logic [IDX_W-1:0] mask;

  assign mask     = size - IDX_W'(1);
  assign next_idx = (prod_idx + STEP) & mask;
  assign room     = (next_idx != cons_idx);
endmodule

// File: rtl/ringcap_ctrl.sv
module ringcap_ctrl #(
  parameter int IDX_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             enable,
  input  logic             room,
  input  logic [IDX_W-1:0] next_idx,
  input  logic             smp_valid,
  input  logic             mem_ready,
  output logic             writable,
  output logic             accept,
  output logic [IDX_W-1:0] prod_idx
);
  assign writable = enable && room;
  assign accept   = writable && smp_valid && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prod_idx <= '0;
    else if (soft_rst) prod_idx <= '0;
    else if (accept)   prod_idx <= next_idx;
  end

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !soft_rst) |=> $stable(prod_idx));
  assert_soft_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> prod_idx == '0);
endmodule

// File: rtl/ringcap_top.sv
module ringcap_top
  import ringcap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              smp_valid,
  input  logic [31:0]       smp_data,
  output logic              smp_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  input  logic              mem_ready
);
  logic              enable, room, writable, accept;
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  size, cons_idx, prod_idx, next_idx;

  ringcap_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .we(reg_we),
    .addr(reg_addr), .wdata(reg_wdata), .prod_idx(prod_idx),
    .rdata(reg_rdata), .enable(enable), .base(base), .size(size),
    .cons_idx(cons_idx)
  );

  ringcap_space #(.IDX_W(IDX_W)) u_space (
    .prod_idx(prod_idx), .cons_idx(cons_idx), .size(size),
    .next_idx(next_idx), .room(room)
  );

  ringcap_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
    .room(room), .next_idx(next_idx), .smp_valid(smp_valid),
    .mem_ready(mem_ready), .writable(writable), .accept(accept),
    .prod_idx(prod_idx)
  );

  assign mem_valid = smp_valid && writable;
  assign smp_ready = mem_ready && writable;
  assign mem_addr  = base + ADDR_W'(prod_idx);
  assign mem_data  = smp_data;

  assert_never_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !soft_rst && !(reg_we && reg_addr[4:2] == 3'd4))
      |=> prod_idx != cons_idx);
  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!mem_valid && !smp_ready));
  assert_take_only_on_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |-> (mem_valid && mem_ready));
endmodule

// File: tb/ringcap_tb_top.sv
module ringcap_tb_top;
  localparam int AW = 32;
  localparam int IW = 8;

  logic clk = 0, rst_n = 0, soft_rst = 0, reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, smp_data = 0, mem_data;
  logic smp_valid = 0, smp_ready, mem_valid, mem_ready = 0;
  logic [AW-1:0] mem_addr;
  int total = 0, fails = 0;
  bit done = 0;

  // behavioural model state
  logic [IW-1:0] m_prod = 0, m_cons = 0, m_size = 0;
  logic [31:0] m_base = 0;
  bit m_en = 0;

  always #5 clk = ~clk;

  ringcap_top #(.ADDR_W(AW), .IDX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_room();
    logic [IW-1:0] mask, nxt;
    mask = m_size - 1;
    nxt  = (m_prod + 4) & mask;
    return m_en && (nxt != m_cons);
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a[4:2])
      3'd0: return {31'd0, m_en};
      3'd1: return m_base;
      3'd2: return 32'(m_size);
      3'd3: return 32'(m_prod);
      3'd4: return 32'(m_cons);
      default: return 32'd0;
    endcase
  endfunction

  // model update at each edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit acc;
      acc = m_room() && smp_valid && mem_ready;
      if (acc) m_prod = (m_prod + 4) & (m_size - 1);
      if (soft_rst) begin m_prod = 0; m_cons = 0; m_en = 0; end
      else if (reg_we) begin
        if (reg_addr[4:2] == 3'd0) m_en = reg_wdata[0];
        if (reg_addr[4:2] == 3'd4) m_cons = reg_wdata[IW-1:0];
      end
      if (reg_we && reg_addr[4:2] == 3'd1) m_base = reg_wdata;
      if (reg_we && reg_addr[4:2] == 3'd2) m_size = reg_wdata[IW-1:0];
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit w;
      w = m_room();
      chk("R4/R6/R8 mem_valid", mem_valid, smp_valid && w);
      chk("R6/R10 smp_ready", smp_ready, mem_ready && w);
      if (mem_valid) begin
        chk("R4 mem_addr", mem_addr, m_base + 32'(m_prod));
        chk("R4 mem_data", mem_data, smp_data);
      end
      chk("R2 reg_rdata", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 smp_ready", smp_ready, 0);
    step();
    rd_chk("R1 enable", 5'h00, 0);
    rd_chk("R1 prod", 5'h0C, 0);
    rd_chk("R1 cons", 5'h10, 0);

    wr(5'h04, 32'h1000);
    wr(5'h08, 32'd16);
    wr(5'h10, 32'd0);
    wr(5'h00, 32'd1);
    rd_chk("R2 base", 5'h04, 32'h1000);
    rd_chk("R2 size", 5'h08, 32'd16);

    // fill a 16-byte ring: three beats then stall
    mem_ready = 1; smp_valid = 1; smp_data = 32'hA0;
    reg_addr = 5'h0C;
    @(negedge clk);
    chk("R4 first addr", mem_addr, 32'h1000);
    repeat (5) begin step(); smp_data = smp_data + 1; end
    @(negedge clk);
    chk("R6 stalled ready", smp_ready, 0);
    chk("R6 stalled valid", mem_valid, 0);
    chk("R6 prod held", reg_rdata, 12);
    step();

    // consumer moves: resume, wrap to zero, stall at 4
    wr(5'h10, 32'd8);
    @(negedge clk);
    chk("R7 resume addr", mem_addr, 32'h100C);
    step();
    @(negedge clk);
    chk("R5 wrap addr", mem_addr, 32'h1000);
    repeat (4) step();
    rd_chk("R7 prod after resume", 5'h0C, 4);

    // sink back-pressure
    wr(5'h10, 32'd12);
    mem_ready = 0;
    repeat (3) step();
    @(negedge clk);
    chk("R10 no take", smp_ready, 0);
    chk("R10 valid offered", mem_valid, 1);
    step();
    rd_chk("R10 prod held", 5'h0C, 4);
    mem_ready = 1;
    repeat (3) step();
    rd_chk("R5 prod step", 5'h0C, 8);

    // producer write ignored
    wr(5'h0C, 32'h40);
    rd_chk("R3 prod unchanged", 5'h0C, 8);

    // disable / re-enable
    wr(5'h00, 32'd0);
    wr(5'h10, 32'd0);
    repeat (3) step();
    @(negedge clk);
    chk("R8 no beat while off", mem_valid, 0);
    step();
    rd_chk("R8 prod held", 5'h0C, 8);
    wr(5'h00, 32'd1);
    @(negedge clk);
    chk("R8 resume addr", mem_addr, 32'h1008);
    step();

    // soft reset
    smp_valid = 0;
    soft_rst = 1; step(); soft_rst = 0;
    rd_chk("R9 prod", 5'h0C, 0);
    rd_chk("R9 cons", 5'h10, 0);
    rd_chk("R9 enable", 5'h00, 0);
    rd_chk("R9 base kept", 5'h04, 32'h1000);

    // randomized traffic on a 32-byte ring
    wr(5'h04, 32'h2000);
    wr(5'h08, 32'd32);
    wr(5'h00, 32'd1);
    for (int i = 0; i < 600; i++) begin
      smp_valid = ($urandom % 4) != 0;
      mem_ready = ($urandom % 3) != 0;
      smp_data  = $urandom;
      reg_addr  = 5'(($urandom % 5) * 4);
      if (i % 9 == 0) begin
        reg_we = 1; reg_addr = 5'h10;
        reg_wdata = 32'((m_prod - 8'(4 * ($urandom % 3))) & (m_size - 1));
      end
      step();
      reg_we = 0;
    end
    smp_valid = 0;
    step();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule